// File: doc/BRIEF.md
# RMII Receive Sideband Status Inserter

This block drives the receive side of a reduced media-independent interface (RMII): the combined carrier/data-valid line and the two-bit receive data bus, both registered on the reference clock. It reads received dibits from an external receive FIFO. It frames them with zero-stuffing at the start of a frame, and with the alternating data-valid pattern while the FIFO drains after carrier loss.

Between frames the receive bus is normally held at zero. With sideband signaling switched on, the block instead puts two status bits on the idle bus. Each bit is picked by its own 3-bit select from a vector of six port status signals. This lets a MAC observe link and error state without management reads. An isolate input overrides the enable and returns the idle bus to zeros.

Carrier detect is taken as already synchronous. The data-valid output rises on the first clock edge after carrier is seen.

Top module: `rmii_rx_oob_ins`

## Requirements
- R1: While rst_ni is low, crs_dv_o is 0, rxd_o is 00 and fifo_rd_o is 0.
- R2: Between frames with oob_en_i = 0, crs_dv_o is 0 and rxd_o is 00.
- R3: isolate_i = 1 forces the idle rxd_o to 00 whatever oob_en_i is.
- R4: Between frames with oob_en_i = 1 and isolate_i = 0, one clock after the inputs are applied, rxd_o[1] equals status_i[sel1_i] and rxd_o[0] equals status_i[sel0_i]. The status bit positions are 0 link, 1 speed, 2 duplex, 3 collision, 4 jabber and 5 receive error. Select codes 6 and 7 give 0.
- R5: carrier_i high between frames sets crs_dv_o to 1 and rxd_o to 00 on the next clock edge.
- R6: During a frame, while carrier_i is high and the FIFO is empty, crs_dv_o stays 1 and rxd_o is 00. This covers both the preamble stuffing and an underrun.
- R7: During a frame, while carrier_i is high and the FIFO is not empty, one dibit is popped each clock. Each popped dibit appears on rxd_o on the next clock, in FIFO order, with crs_dv_o at 1.
- R8: When carrier_i is low and the FIFO still holds data, the dibits keep coming out one per clock. On the first of these dibits crs_dv_o is 0, and it then alternates 1, 0, 1, ... on each later dibit.
- R9: At the end of a frame, once carrier_i is low and the FIFO is empty, the next clock gives crs_dv_o = 0 and the idle value on rxd_o. fifo_rd_o is never high while fifo_empty_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | RMII reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| carrier_i | input | 1 | Receive activity detect, synchronous |
| fifo_empty_i | input | 1 | Receive FIFO empty |
| fifo_data_i | input | 2 | Dibit at the FIFO head |
| fifo_rd_o | output | 1 | Pop the FIFO head this cycle |
| status_i | input | 6 | Port status: link, speed, duplex, collision, jabber, rx error |
| sel1_i | input | 3 | Status select for rxd_o[1] |
| sel0_i | input | 3 | Status select for rxd_o[0] |
| oob_en_i | input | 1 | Enable sideband status on the idle bus |
| isolate_i | input | 1 | Isolate override, forces the idle bus to zero |
| crs_dv_o | output | 1 | Carrier sense / data valid |
| rxd_o | output | 2 | Receive dibit |

## Verification
The idle path is swept over every pair of select codes against all 64 status vectors. This shows whether each lane decodes its own select, whether the two lanes are swapped, and whether the unused codes leak a status bit. The enable/isolate combinations are swept with a fixed status vector to separate the gating from the selection. Two frames are run. One drops carrier with six dibits still queued, which exposes the order and phase of the data-valid toggling. The other runs the FIFO dry with carrier still up and then drops carrier, which separates underrun stuffing from the end-of-frame return to the status value.

// File: rtl/rmii_oob_pkg.sv
package rmii_oob_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACT   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_st_e;

  localparam int unsigned DIBIT_W = 2;
  localparam int unsigned N_STAT  = 6;
  localparam int unsigned SEL_W   = 3;
endpackage

// File: rtl/rmii_oob_stat_sel.sv
module rmii_oob_stat_sel #(
  parameter int unsigned N_STAT = 6,
  parameter int unsigned SEL_W  = 3
) (
  input  logic [N_STAT-1:0] stat_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              bit_o
);
  logic [N_STAT-1:0] hit;

  // codes at or beyond N_STAT hit nothing and give 0
  for (genvar i = 0; i < N_STAT; i++) begin : g_hit
    assign hit[i] = (sel_i == SEL_W'(i)) & stat_i[i];
  end

  assign bit_o = |hit;
endmodule

// File: rtl/rmii_oob_seq.sv
module rmii_oob_seq
  import rmii_oob_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               carrier_i,
  input  logic               fifo_empty_i,
  input  logic [DIBIT_W-1:0] fifo_data_i,
  input  logic [DIBIT_W-1:0] idle_val_i,
  output logic               fifo_rd_o,
  output logic               crs_dv_o,
  output logic [DIBIT_W-1:0] rxd_o,
  output seq_st_e            st_o
);
  seq_st_e            st_q, st_d;
  logic               crs_q, crs_d;
  logic [DIBIT_W-1:0] rxd_q, rxd_d;
  logic               rd;

  always_comb begin
    st_d  = st_q;
    crs_d = 1'b0;
    rxd_d = idle_val_i;
    rd    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (carrier_i) begin
          st_d  = ST_ACT;
          crs_d = 1'b1;
          rxd_d = '0;
        end
      end
      ST_ACT: begin
        if (carrier_i) begin
          crs_d = 1'b1;
          rxd_d = '0;
          if (!fifo_empty_i) begin
            rd    = 1'b1;
            rxd_d = fifo_data_i;
          end
        end else if (!fifo_empty_i) begin
          // carrier gone, data still queued: start toggling low
          st_d  = ST_DRAIN;
          rd    = 1'b1;
          rxd_d = fifo_data_i;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_DRAIN: begin
        if (!fifo_empty_i) begin
          rd    = 1'b1;
          rxd_d = fifo_data_i;
          crs_d = ~crs_q;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      crs_q <= 1'b0;
      rxd_q <= '0;
    end else begin
      st_q  <= st_d;
      crs_q <= crs_d;
      rxd_q <= rxd_d;
    end
  end

  assign fifo_rd_o = rd;
  assign crs_dv_o  = crs_q;
  assign rxd_o     = rxd_q;
  assign st_o      = st_q;
endmodule

// File: rtl/rmii_rx_oob_ins.sv
module rmii_rx_oob_ins
  import rmii_oob_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               carrier_i,
  input  logic               fifo_empty_i,
  input  logic [DIBIT_W-1:0] fifo_data_i,
  output logic               fifo_rd_o,
  input  logic [N_STAT-1:0]  status_i,
  input  logic [SEL_W-1:0]   sel1_i,
  input  logic [SEL_W-1:0]   sel0_i,
  input  logic               oob_en_i,
  input  logic               isolate_i,
  output logic               crs_dv_o,
  output logic [DIBIT_W-1:0] rxd_o
);
  logic [DIBIT_W-1:0][SEL_W-1:0] sel_pk;
  logic [DIBIT_W-1:0]            stat_bits;
  logic [DIBIT_W-1:0]            idle_val;
  logic                          oob_on;
  seq_st_e                       st_q;

  assign sel_pk = {sel1_i, sel0_i};

  for (genvar g = 0; g < DIBIT_W; g++) begin : g_lane
    rmii_oob_stat_sel #(
      .N_STAT(N_STAT),
      .SEL_W (SEL_W)
    ) u_sel (
      .stat_i(status_i),
      .sel_i (sel_pk[g]),
      .bit_o (stat_bits[g])
    );
  end

  assign oob_on   = oob_en_i & ~isolate_i;
  assign idle_val = oob_on ? stat_bits : '0;

  rmii_oob_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .carrier_i   (carrier_i),
    .fifo_empty_i(fifo_empty_i),
    .fifo_data_i (fifo_data_i),
    .idle_val_i  (idle_val),
    .fifo_rd_o   (fifo_rd_o),
    .crs_dv_o    (crs_dv_o),
    .rxd_o       (rxd_o),
    .st_o        (st_q)
  );
endmodule

// File: rtl/rmii_rx_oob_ins_chk.sv
module rmii_rx_oob_ins_chk
  import rmii_oob_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               carrier_i,
  input logic               fifo_empty_i,
  input logic               fifo_rd_o,
  input logic               oob_en_i,
  input logic               isolate_i,
  input logic               crs_dv_o,
  input logic [DIBIT_W-1:0] rxd_o,
  input seq_st_e            st_q
);
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!crs_dv_o && rxd_o == '0 && !fifo_rd_o)); // R1

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !carrier_i && (!oob_en_i || isolate_i))
      |=> (!crs_dv_o && rxd_o == '0)); // R3

  AST_CRS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && carrier_i) |=> (crs_dv_o && rxd_o == '0)); // R5

  AST_STUFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACT && carrier_i && fifo_empty_i) |=> (crs_dv_o && rxd_o == '0)); // R6

  AST_DRAIN_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DRAIN && !fifo_empty_i) |=> (crs_dv_o != $past(crs_dv_o))); // R8

  AST_NO_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> !fifo_empty_i); // R9
endmodule

bind rmii_rx_oob_ins rmii_rx_oob_ins_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .carrier_i   (carrier_i),
  .fifo_empty_i(fifo_empty_i),
  .fifo_rd_o   (fifo_rd_o),
  .oob_en_i    (oob_en_i),
  .isolate_i   (isolate_i),
  .crs_dv_o    (crs_dv_o),
  .rxd_o       (rxd_o),
  .st_q        (st_q)
);

// File: tb/rmii_rx_oob_ins_tb.sv
module rmii_rx_oob_ins_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       carrier = 1'b0;
  logic       fifo_rd;
  logic [5:0] status = '0;
  logic [2:0] sel1 = '0;
  logic [2:0] sel0 = '0;
  logic       oob_en = 1'b0;
  logic       isolate = 1'b0;
  logic       crs_dv;
  logic [1:0] rxd;

  logic [1:0] fq [0:63];
  int         wr_p = 0;
  int         rd_p = 0;
  logic       fifo_empty;
  logic [1:0] fifo_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign fifo_empty = (rd_p == wr_p);
  assign fifo_data  = fq[rd_p[5:0]];

  always @(posedge clk) if (fifo_rd) rd_p <= rd_p + 1;

  rmii_rx_oob_ins u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .carrier_i   (carrier),
    .fifo_empty_i(fifo_empty),
    .fifo_data_i (fifo_data),
    .fifo_rd_o   (fifo_rd),
    .status_i    (status),
    .sel1_i      (sel1),
    .sel0_i      (sel0),
    .oob_en_i    (oob_en),
    .isolate_i   (isolate),
    .crs_dv_o    (crs_dv),
    .rxd_o       (rxd)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic logic pick(input logic [5:0] st, input logic [2:0] s);
    return (s < 3'd6) ? st[s] : 1'b0;
  endfunction

  task automatic push(input logic [1:0] d);
    fq[wr_p[5:0]] = d;
    wr_p++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {1'b0, fifo_rd, crs_dv, rxd}, 4'b0000);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 / R3: enable and isolate combinations with a fixed status vector
    status = 6'b111111;
    sel1 = 3'd0;
    sel0 = 3'd5;
    for (int m = 0; m < 4; m++) begin
      oob_en  = m[0];
      isolate = m[1];
      @(posedge clk);
      @(negedge clk);
      if (m[1]) check("R3 isolate idle", {2'b00, crs_dv, rxd[1]}, 4'b0000);
      if (m[1]) check("R3 isolate idle", {3'b000, rxd[0]}, 4'b0000);
      if (m == 0) check("R2 disabled idle", {1'b0, crs_dv, rxd}, 4'b0000);
      if (m == 1) check("R4 enabled idle", {1'b0, crs_dv, rxd}, 4'b0011);
    end

    // R4: every select pair against every status vector
    oob_en = 1'b1;
    isolate = 1'b0;
    for (int s = 0; s < 64; s++) begin
      for (int p = 0; p < 64; p++) begin
        status = s[5:0];
        sel1 = p[5:3];
        sel0 = p[2:0];
        @(posedge clk);
        @(negedge clk);
        check("R4 status select",
              {1'b0, crs_dv, rxd},
              {2'b00, pick(s[5:0], p[5:3]), pick(s[5:0], p[2:0])});
      end
    end

    // frame 1: preamble stuffing, data, drain with toggling
    status = 6'b000101;
    sel1 = 3'd0;
    sel0 = 3'd2;
    @(posedge clk);
    @(negedge clk);
    check("R4 idle before frame", {2'b00, rxd}, 4'b0011);
    carrier = 1'b1;
    @(negedge clk);
    check("R5 crs start", {1'b0, crs_dv, rxd}, 4'b0100);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check("R6 preamble stuff", {1'b0, crs_dv, rxd}, 4'b0100);
    end
    for (int k = 0; k < 10; k++) push(2'((k * 3 + 1) % 4));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R7 data order", {1'b0, crs_dv, rxd}, {2'b01, 2'((k * 3 + 1) % 4)});
    end
    carrier = 1'b0;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      check("R8 drain toggle", {1'b0, crs_dv, rxd},
            {1'b0, j[0], 2'(((j + 4) * 3 + 1) % 4)});
    end
    @(negedge clk);
    check("R9 end of frame idle", {1'b0, crs_dv, rxd}, 4'b0011);
    check("R9 no read when empty", {3'b000, fifo_rd}, 4'b0000);

    // frame 2: data, underrun stuffing, carrier drop with FIFO empty
    status = 6'b100000;
    sel1 = 3'd7;
    sel0 = 3'd5;
    carrier = 1'b1;
    push(2'b10);
    push(2'b01);
    @(negedge clk);
    check("R5 crs start f2", {1'b0, crs_dv, rxd}, 4'b0100);
    @(negedge clk);
    check("R7 data f2", {1'b0, crs_dv, rxd}, 4'b0110);
    @(negedge clk);
    check("R7 data f2", {1'b0, crs_dv, rxd}, 4'b0101);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check("R6 underrun stuff", {1'b0, crs_dv, rxd}, 4'b0100);
    end
    carrier = 1'b0;
    @(negedge clk);
    check("R9 idle after empty drop", {1'b0, crs_dv, rxd}, 4'b0001);
    isolate = 1'b1;
    @(negedge clk);
    check("R3 isolate after frame", {1'b0, crs_dv, rxd}, 4'b0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule